// File: doc/BRIEF.md
# Multi-Cycle Accumulator CPU Control Sequencer

This block is the control sequencer of a small 8-bit accumulator processor. It steps every instruction through four states: fetch, decode, execute and store. In each state it issues one-hot control strobes to the program counter, the memory, the instruction register, the ALU, the accumulator and the flags register. The strobes depend on the current state and on the 4-bit opcode held in the instruction register. The datapath, the memory array and the ALU sit outside the block and only obey these strobes.

Conditional jumps look at the zero flag from the flags register. A halt opcode freezes the sequencer until reset. Reset is asynchronous and active-high. It returns the sequencer to fetch and silences every strobe at once, without waiting for a clock edge.

The strobes are combinational outputs of the state register and the opcode input. A strobe is valid for the whole cycle in which the state code shows its state. The instruction register loads at the end of fetch, so the opcode only has to be stable from decode onwards.

Top module: `ctl_sequencer`

## Requirements
- R1: The state code advances on each rising clock edge in the order fetch (00), decode (01), execute (10), store (11), then back to fetch (00).
- R2: While reset is high, the state code is 00, every strobe is 0 and halted is 0, with no clock edge needed. Reset also clears a latched halt.
- R3: In fetch, exactly pc_drive, mem_read and ir_load are 1. In decode, only pc_inc is 1. Neither state depends on the opcode.
- R4: For opcode 0x1 (load accumulator), execute raises ir_addr_drive and mem_read. Store raises ram_drive, acc_load and flags_load.
- R5: For opcode 0x2 (store accumulator), execute raises ir_addr_drive. Store raises ir_addr_drive, mem_write and acc_drive, and does not raise flags_load.
- R6: For the ALU opcodes 0x3 to 0xA, store raises alu_drive, acc_load and flags_load, with alu_sel equal to the opcode minus 3 (0x3→0 … 0xA→7). Execute raises ir_addr_drive and mem_read for 0x3 to 0x7 and no strobe for 0x8 to 0xA.
- R7: In execute, opcodes 0xB, 0xC and 0xD raise ir_addr_drive. They raise pc_load as follows: always for 0xB, only with zero_flag=1 for 0xC, and only with zero_flag=0 for 0xD. Their store state raises no strobe.
- R8: Opcode 0xF raises halted in execute. From then on the state code stays 10, halted stays 1 and every strobe stays 0 until reset, whatever the opcode and the flag do.
- R9: Opcodes 0x0 and 0xE raise no strobe in execute or store. zero_flag has no effect on any opcode other than 0xC and 0xD.
- R10: In every cycle at most one of pc_drive and ir_addr_drive is 1, and at most one of ram_drive, alu_drive and acc_drive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| opcode | input | 4 | Opcode field from the instruction register |
| zero_flag | input | 1 | Zero flag from the flags register |
| pc_inc | output | 1 | Program counter increment |
| pc_load | output | 1 | Program counter load (jump) |
| pc_drive | output | 1 | Program counter drives the address bus |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| ram_drive | output | 1 | RAM drives the data bus |
| ir_load | output | 1 | Instruction register load |
| ir_addr_drive | output | 1 | Instruction register address field drives the address bus |
| alu_sel | output | 3 | ALU operation select |
| alu_drive | output | 1 | ALU drives the data bus |
| acc_load | output | 1 | Accumulator load |
| acc_drive | output | 1 | Accumulator drives the data bus |
| flags_load | output | 1 | Flags register load |
| halted | output | 1 | Halt indicator |
| state_code | output | 2 | Current state code |

## Verification
The strobes are decoded combinationally from the state register and the opcode. The bench sets the opcode and flag while the sequencer is in fetch, then reads the outputs one cycle at a time at the falling edge. Each of the four readings therefore sees the state entered at the preceding rising edge, and the execute and store results of an opcode are due two and three edges after its fetch. Halt shows up within the execute cycle and must still hold after several more edges. Reset is applied between edges and checked 1 ns later, before any edge, which shows its asynchronous effect.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    localparam int OPC_W     = 4;
    localparam int ALU_SEL_W = 3;
    localparam int STATE_W   = 2;
    localparam logic [OPC_W-1:0] ALU_BASE = OPC_W'(3);

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 2'b00,
        ST_DECODE = 2'b01,
        ST_EXEC   = 2'b10,
        ST_STORE  = 2'b11
    } seq_state_e;

    typedef enum logic [OPC_W-1:0] {
        OP_IDLE = 4'h0,
        OP_LOAD = 4'h1,
        OP_SAVE = 4'h2,
        OP_ADD  = 4'h3,
        OP_SUB  = 4'h4,
        OP_AND  = 4'h5,
        OP_OR   = 4'h6,
        OP_XOR  = 4'h7,
        OP_INV  = 4'h8,
        OP_SHL  = 4'h9,
        OP_SHR  = 4'hA,
        OP_GO   = 4'hB,
        OP_GOZ  = 4'hC,
        OP_GONZ = 4'hD,
        OP_RSVD = 4'hE,
        OP_STOP = 4'hF
    } opcode_e;

    typedef struct packed {
        logic                 pc_inc;
        logic                 pc_load;
        logic                 pc_drive;
        logic                 mem_read;
        logic                 mem_write;
        logic                 ram_drive;
        logic                 ir_load;
        logic                 ir_addr_drive;
        logic [ALU_SEL_W-1:0] alu_sel;
        logic                 alu_drive;
        logic                 acc_load;
        logic                 acc_drive;
        logic                 flags_load;
        logic                 halt;
    } ctrl_word_t;

    function automatic logic is_alu_op(opcode_e op);
        return (op >= OP_ADD) && (op <= OP_SHR);
    endfunction

    function automatic logic needs_operand(opcode_e op);
        return (op == OP_LOAD) || ((op >= OP_ADD) && (op <= OP_XOR));
    endfunction

    function automatic logic is_jump(opcode_e op);
        return (op == OP_GO) || (op == OP_GOZ) || (op == OP_GONZ);
    endfunction

    function automatic logic jump_taken(opcode_e op, logic zf);
        logic taken;
        case (op)
            OP_GO:   taken = 1'b1;
            OP_GOZ:  taken = zf;
            OP_GONZ: taken = ~zf;
            default: taken = 1'b0;
        endcase
        return taken;
    endfunction

    function automatic logic [ALU_SEL_W-1:0] alu_code(opcode_e op);
        logic [OPC_W-1:0] diff;
        diff = op - ALU_BASE;
        return diff[ALU_SEL_W-1:0];
    endfunction

    function automatic ctrl_word_t micro_word(seq_state_e st, opcode_e op, logic zf);
        ctrl_word_t w;
        w = '0;
        case (st)
            ST_FETCH: begin
                w.pc_drive = 1'b1;
                w.mem_read = 1'b1;
                w.ir_load  = 1'b1;
            end
            ST_DECODE: begin
                w.pc_inc = 1'b1;
            end
            ST_EXEC: begin
                if (op == OP_STOP) begin
                    w.halt = 1'b1;
                end else if (needs_operand(op)) begin
                    w.ir_addr_drive = 1'b1;
                    w.mem_read      = 1'b1;
                end else if (op == OP_SAVE) begin
                    w.ir_addr_drive = 1'b1;
                end else if (is_jump(op)) begin
                    w.ir_addr_drive = 1'b1;
                    w.pc_load       = jump_taken(op, zf);
                end
            end
            ST_STORE: begin
                if (op == OP_LOAD) begin
                    w.ram_drive  = 1'b1;
                    w.acc_load   = 1'b1;
                    w.flags_load = 1'b1;
                end else if (op == OP_SAVE) begin
                    w.ir_addr_drive = 1'b1;
                    w.mem_write     = 1'b1;
                    w.acc_drive     = 1'b1;
                end else if (is_alu_op(op)) begin
                    w.alu_drive  = 1'b1;
                    w.acc_load   = 1'b1;
                    w.flags_load = 1'b1;
                    w.alu_sel    = alu_code(op);
                end
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ctl_seq_state.sv
module ctl_seq_state
    import ctl_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    output seq_state_e state_q,
    output logic       halt_q
);

    seq_state_e state_d;
    logic       halt_d;

    always_comb begin
        halt_d  = halt_q | stop_req;
        state_d = state_q;
        if (!halt_d) begin
            state_d = seq_state_e'(state_q + STATE_W'(1));
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_FETCH;
            halt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            halt_q  <= halt_d;
        end
    end

endmodule

// File: rtl/ctl_seq_ucode.sv
module ctl_seq_ucode
    import ctl_seq_pkg::*;
(
    input  seq_state_e       state_q,
    input  logic             halt_q,
    input  logic [OPC_W-1:0] opcode,
    input  logic             zero_flag,
    output ctrl_word_t       word
);

    always_comb begin
        if (halt_q) begin
            word      = '0;
            word.halt = 1'b1;
        end else begin
            word = micro_word(state_q, opcode_e'(opcode), zero_flag);
        end
    end

endmodule

// File: rtl/ctl_seq_drive.sv
module ctl_seq_drive
    import ctl_seq_pkg::*;
(
    input  logic               rst,
    input  ctrl_word_t         word,
    input  seq_state_e         state_q,
    output ctrl_word_t         word_out,
    output logic [STATE_W-1:0] state_out
);

    always_comb begin
        if (rst) begin
            word_out  = '0;
            state_out = ST_FETCH;
        end else begin
            word_out  = word;
            state_out = state_q;
        end
    end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import ctl_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OPC_W-1:0]     opcode,
    input  logic                 zero_flag,
    output logic                 pc_inc,
    output logic                 pc_load,
    output logic                 pc_drive,
    output logic                 mem_read,
    output logic                 mem_write,
    output logic                 ram_drive,
    output logic                 ir_load,
    output logic                 ir_addr_drive,
    output logic [ALU_SEL_W-1:0] alu_sel,
    output logic                 alu_drive,
    output logic                 acc_load,
    output logic                 acc_drive,
    output logic                 flags_load,
    output logic                 halted,
    output logic [STATE_W-1:0]   state_code
);

    seq_state_e state_q;
    logic       halt_q;
    ctrl_word_t word;
    ctrl_word_t word_out;

    ctl_seq_state u_state (
        .clk      (clk),
        .rst      (rst),
        .stop_req (word.halt),
        .state_q  (state_q),
        .halt_q   (halt_q)
    );

    ctl_seq_ucode u_ucode (
        .state_q   (state_q),
        .halt_q    (halt_q),
        .opcode    (opcode),
        .zero_flag (zero_flag),
        .word      (word)
    );

    ctl_seq_drive u_drive (
        .rst       (rst),
        .word      (word),
        .state_q   (state_q),
        .word_out  (word_out),
        .state_out (state_code)
    );

    assign pc_inc        = word_out.pc_inc;
    assign pc_load       = word_out.pc_load;
    assign pc_drive      = word_out.pc_drive;
    assign mem_read      = word_out.mem_read;
    assign mem_write     = word_out.mem_write;
    assign ram_drive     = word_out.ram_drive;
    assign ir_load       = word_out.ir_load;
    assign ir_addr_drive = word_out.ir_addr_drive;
    assign alu_sel       = word_out.alu_sel;
    assign alu_drive     = word_out.alu_drive;
    assign acc_load      = word_out.acc_load;
    assign acc_drive     = word_out.acc_drive;
    assign flags_load    = word_out.flags_load;
    assign halted        = word_out.halt;

endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk
    import ctl_seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [OPC_W-1:0]     opcode,
    input logic                 zero_flag,
    input logic                 pc_inc,
    input logic                 pc_load,
    input logic                 pc_drive,
    input logic                 mem_read,
    input logic                 mem_write,
    input logic                 ram_drive,
    input logic                 ir_load,
    input logic                 ir_addr_drive,
    input logic [ALU_SEL_W-1:0] alu_sel,
    input logic                 alu_drive,
    input logic                 acc_load,
    input logic                 acc_drive,
    input logic                 flags_load,
    input logic                 halted,
    input logic [STATE_W-1:0]   state_code
);

    // R1: state order
    a_r1_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b00) |=> (state_code == 2'b01));
    a_r1_decode_to_exec: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b01) |=> (state_code == 2'b10));
    a_r1_exec_to_store: assert property (@(posedge clk) disable iff (rst)
        ((state_code == 2'b10) && !halted) |=> (state_code == 2'b11));
    a_r1_store_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b11) |=> (state_code == 2'b00));

    // R2: outputs silent while reset is high
    always @(posedge clk) begin
        if (rst) begin
            a_r2_reset_quiet: assert (state_code == 2'b00 && !halted && !pc_drive
                && !mem_read && !ir_load && !pc_inc && !mem_write && !acc_load);
        end
    end

    // R3: fetch strobes
    a_r3_fetch_strobes: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b00) |-> (pc_drive && mem_read && ir_load && !pc_inc));

    // R7: conditional jump on zero flag
    a_r7_jz_gate: assert property (@(posedge clk) disable iff (rst)
        ((state_code == 2'b10) && !halted && opcode == 4'hC) |-> (pc_load == zero_flag));
    a_r7_jnz_gate: assert property (@(posedge clk) disable iff (rst)
        ((state_code == 2'b10) && !halted && opcode == 4'hD) |-> (pc_load == !zero_flag));

    // R8: halt is sticky and freezes the state
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(state_code) && !pc_inc && !mem_read));

    // R10: bus driver exclusivity
    a_r10_addr_bus: assert property (@(posedge clk) disable iff (rst)
        $countones({pc_drive, ir_addr_drive}) <= 1);
    a_r10_data_bus: assert property (@(posedge clk) disable iff (rst)
        $countones({ram_drive, alu_drive, acc_drive}) <= 1);

endmodule

bind ctl_sequencer ctl_sequencer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .opcode        (opcode),
    .zero_flag     (zero_flag),
    .pc_inc        (pc_inc),
    .pc_load       (pc_load),
    .pc_drive      (pc_drive),
    .mem_read      (mem_read),
    .mem_write     (mem_write),
    .ram_drive     (ram_drive),
    .ir_load       (ir_load),
    .ir_addr_drive (ir_addr_drive),
    .alu_sel       (alu_sel),
    .alu_drive     (alu_drive),
    .acc_load      (acc_load),
    .acc_drive     (acc_drive),
    .flags_load    (flags_load),
    .halted        (halted),
    .state_code    (state_code)
);

// File: tb/ctl_sequencer_test.sv
module ctl_sequencer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic       zero_flag = 1'b0;
    logic pc_inc, pc_load, pc_drive, mem_read, mem_write, ram_drive, ir_load;
    logic ir_addr_drive, alu_drive, acc_load, acc_drive, flags_load, halted;
    logic [2:0] alu_sel;
    logic [1:0] state_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ctl_sequencer uut (
        .clk(clk), .rst(rst), .opcode(opcode), .zero_flag(zero_flag),
        .pc_inc(pc_inc), .pc_load(pc_load), .pc_drive(pc_drive),
        .mem_read(mem_read), .mem_write(mem_write), .ram_drive(ram_drive),
        .ir_load(ir_load), .ir_addr_drive(ir_addr_drive), .alu_sel(alu_sel),
        .alu_drive(alu_drive), .acc_load(acc_load), .acc_drive(acc_drive),
        .flags_load(flags_load), .halted(halted), .state_code(state_code)
    );

    // Observed word: {halted, state[1:0], pc_inc, pc_load, pc_drive, mem_read,
    // mem_write, ram_drive, ir_load, ir_addr_drive, alu_sel[2:0], alu_drive,
    // acc_load, acc_drive, flags_load}
    logic [17:0] obs;
    assign obs = {halted, state_code, pc_inc, pc_load, pc_drive, mem_read, mem_write,
                  ram_drive, ir_load, ir_addr_drive, alu_sel, alu_drive, acc_load,
                  acc_drive, flags_load};

    localparam logic [14:0] W_FETCH  = 15'h1900;
    localparam logic [14:0] W_DECODE = 15'h4000;

    // {opcode, zero_flag, execute strobes, store strobes}
    localparam logic [34:0] VEC [0:18] = '{
        {4'h0, 1'b0, 15'h0000, 15'h0000},
        {4'h1, 1'b0, 15'h0880, 15'h0205},
        {4'h1, 1'b1, 15'h0880, 15'h0205},
        {4'h2, 1'b0, 15'h0080, 15'h0482},
        {4'h3, 1'b0, 15'h0880, 15'h000D},
        {4'h4, 1'b1, 15'h0880, 15'h001D},
        {4'h5, 1'b0, 15'h0880, 15'h002D},
        {4'h6, 1'b0, 15'h0880, 15'h003D},
        {4'h7, 1'b0, 15'h0880, 15'h004D},
        {4'h8, 1'b0, 15'h0000, 15'h005D},
        {4'h9, 1'b1, 15'h0000, 15'h006D},
        {4'hA, 1'b0, 15'h0000, 15'h007D},
        {4'hB, 1'b0, 15'h2080, 15'h0000},
        {4'hB, 1'b1, 15'h2080, 15'h0000},
        {4'hC, 1'b1, 15'h2080, 15'h0000},
        {4'hC, 1'b0, 15'h0080, 15'h0000},
        {4'hD, 1'b0, 15'h2080, 15'h0000},
        {4'hD, 1'b1, 15'h0080, 15'h0000},
        {4'hE, 1'b1, 15'h0000, 15'h0000}
    };

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'h1:             return "R4";
            4'h2:             return "R5";
            4'hB, 4'hC, 4'hD: return "R7";
            4'h0, 4'hE:       return "R9";
            default:          return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%05h expected=%05h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        // R2: reset state
        repeat (2) @(negedge clk);
        #1 check("R2 reset state", obs, 18'h0);
        rst = 1'b0;
        #1 check("R3 first fetch", obs, {1'b0, 2'b00, W_FETCH});

        // Vector table: one full instruction per entry (R1, R3, R4-R7, R9, R10)
        foreach (VEC[i]) begin
            opcode    = VEC[i][34:31];
            zero_flag = VEC[i][30];
            #1 check({"R3 R1 fetch ", tag_of(opcode)}, obs, {1'b0, 2'b00, W_FETCH});
            @(negedge clk);
            #1 check({"R3 R1 decode ", tag_of(opcode)}, obs, {1'b0, 2'b01, W_DECODE});
            @(negedge clk);
            #1 check({"R1 R10 execute ", tag_of(opcode)}, obs, {1'b0, 2'b10, VEC[i][29:15]});
            @(negedge clk);
            #1 check({"R1 R10 store ", tag_of(opcode)}, obs, {1'b0, 2'b11, VEC[i][14:0]});
            @(negedge clk);
        end

        // R2: asynchronous reset in the middle of execute
        opcode = 4'h1; zero_flag = 1'b0;
        @(negedge clk); @(negedge clk);
        #1 check("R4 execute before reset", obs, {1'b0, 2'b10, 15'h0880});
        #4 rst = 1'b1;
        #1 check("R2 async reset mid-cycle", obs, 18'h0);
        @(negedge clk); rst = 1'b0;
        #1 check("R2 fetch after reset", obs, {1'b0, 2'b00, W_FETCH});

        // R8: halt
        opcode = 4'hF;
        @(negedge clk); @(negedge clk);
        #1 check("R8 halt raised in execute", obs, {1'b1, 2'b10, 15'h0});
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k == 2) begin opcode = 4'h1; zero_flag = 1'b1; end
            #1 check("R8 halt persists", obs, {1'b1, 2'b10, 15'h0});
        end

        // R2: reset clears halt
        #3 rst = 1'b1;
        #1 check("R2 reset clears halt", obs, 18'h0);
        @(negedge clk); rst = 1'b0; opcode = 4'h0;
        #1 check("R2 R1 fetch after halt reset", obs, {1'b0, 2'b00, W_FETCH});
        @(negedge clk);
        #1 check("R1 decode after halt reset", obs, {1'b0, 2'b01, W_DECODE});

        summary();
    end

endmodule